// File: doc/BRIEF.md
# Indexed Host Register Port with Packet Windows

This block is the host-facing register front end of a small Ethernet MAC. The host sees only two locations, chosen by `bus_cmd`. A write with `bus_cmd` high stores an 8-bit register number. A later access with `bus_cmd` low reads or writes the register that number selects. A few numbers do not select a plain register. Instead they open a streaming window onto the receive or transmit packet memory. Each window has its own byte pointer, and some windows advance that pointer by the data-port width on every access.

The MAC datapath is replaced by two stand-ins. A fixed-duration transmit model clears the send request and raises the completion flags. A loader port, driven by the testbench, fills the receive memory and raises a "frame arrived" event. Receive entries are stored as a four-byte header followed by the payload. The header is a ready marker (0x01 means a frame, 0x00 means end of chain), then a status byte, then a 16-bit length with the low byte first. The block passes these bytes to the host without changing them.

Top module: `idx_host_if`

## Requirements
- R1: A data-port access targets the register whose number was last written with `bus_cmd`=1. An index with no register reads 0, and writes to it are ignored. A read with `bus_cmd`=1 returns the stored index.
- R2: Indices 0x28, 0x29, 0x2A and 0x2B read 0x46, 0x0A, 0x00 and 0x90. Index 0x2C reads the `REV_CODE` parameter, which defaults to 0x1A.
- R3: Index 0xF0 returns DATA_W/8 receive-memory bytes starting at the read pointer, with the lowest address in bits 7:0. Reading it does not move the pointer.
- R4: Index 0xF2 returns the same data as 0xF0, then advances the read pointer by DATA_W/8. The pointer is read and written at 0xF4 (low byte) and 0xF5 (high byte).
- R5: Each data write at index 0xF8 stores DATA_W/8 bytes into transmit memory at the write pointer, with bits 7:0 at the lowest address, then advances the pointer by DATA_W/8. The pointer is read and written at 0xFA (low byte) and 0xFB (high byte).
- R6: The read pointer wraps modulo RX_DEPTH, and the write pointer wraps modulo TX_DEPTH. This applies both to the bytes of one access and to the pointer advance.
- R7: Index 0xFC holds the low byte and index 0xFD the high byte of the transmit length. Both read back what was written.
- R8: Writing 1 to bit 0 of index 0x02 while idle starts a send. Bit 0 then reads 1 for TX_CYCLES clocks and clears itself. On the clock edge where it clears, bit 2 of index 0x01 and bit 1 of index 0xFE are set. Writing 1 to bit 2 of index 0x01 clears that bit.
- R9: Bits 5:0 of index 0xFE are write-one-to-clear, and writing 0 to a bit leaves it unchanged. A pulse on `rx_arrive` sets bit 0. A set event in the same cycle as a clear wins.
- R10: Bits 7:6 of index 0xFE read the data-port width code: 00 for 16 bits, 01 for 32 bits, 10 for 8 bits. Writes do not change these bits.
- R11: Writing 1 to bit 0 of index 0x00 starts a soft reset. Bit 0 then reads 1 for RST_CLKS clocks (default 16). While the reset runs, every register except the ID registers and the index is held at its default value, and data writes are ignored. Bits 2:1 of index 0x00 are the loopback select and read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_cmd | input | 1 | 1 selects the index location, 0 selects the data location |
| bus_wr | input | 1 | Host write strobe, one cycle per access |
| bus_rd | input | 1 | Host read strobe, one cycle per access |
| bus_wdata | input | DATA_W | Host write data |
| bus_rdata | output | DATA_W | Host read data, combinational from the current index |
| rx_ld_we | input | 1 | Receive-memory loader write enable |
| rx_ld_addr | input | $clog2(RX_DEPTH) | Receive-memory loader byte address |
| rx_ld_data | input | 8 | Receive-memory loader byte |
| rx_arrive | input | 1 | One-cycle pulse: a received frame is ready |
| tx_peek_addr | input | $clog2(TX_DEPTH) | MAC-side transmit-memory byte address |
| tx_peek_data | output | 8 | MAC-side transmit-memory byte |

## Verification
The hardest cases to reach are the ones where two things meet: a pointer that wraps in the middle of a multi-byte access, and a clear arriving in the same cycle as a set event. The bench uses a 32-bit port to reach the wrap. It moves each pointer to two bytes below the region end through the pointer registers, then makes one access, so the word splits across the boundary. For the set-versus-clear case, the bench pulses `rx_arrive` in the same clock as a write-one-to-clear of bit 0. The soft reset is probed from the ports alone. The bench issues a data write while the reset runs, then counts clocks to the exact edge where bit 0 of index 0x00 drops.

// File: rtl/ihf_pkg.sv
package ihf_pkg;

    // register numbers decoded by the data port
    localparam logic [7:0] IX_NCTL  = 8'h00;
    localparam logic [7:0] IX_NSTAT = 8'h01;
    localparam logic [7:0] IX_TCTL  = 8'h02;
    localparam logic [7:0] IX_ID0   = 8'h28;
    localparam logic [7:0] IX_ID1   = 8'h29;
    localparam logic [7:0] IX_ID2   = 8'h2A;
    localparam logic [7:0] IX_ID3   = 8'h2B;
    localparam logic [7:0] IX_REV   = 8'h2C;
    localparam logic [7:0] IX_RXPK  = 8'hF0;
    localparam logic [7:0] IX_RXINC = 8'hF2;
    localparam logic [7:0] IX_RXP_L = 8'hF4;
    localparam logic [7:0] IX_RXP_H = 8'hF5;
    localparam logic [7:0] IX_TXWR  = 8'hF8;
    localparam logic [7:0] IX_TXP_L = 8'hFA;
    localparam logic [7:0] IX_TXP_H = 8'hFB;
    localparam logic [7:0] IX_LEN_L = 8'hFC;
    localparam logic [7:0] IX_LEN_H = 8'hFD;
    localparam logic [7:0] IX_IRQ   = 8'hFE;

    localparam logic [31:0] DEV_ID = 32'h90000A46;

    // width code reported in the top two bits of the event register
    function automatic logic [1:0] width_code(int dw);
        if (dw == 16)      return 2'b00;
        else if (dw == 32) return 2'b01;
        else               return 2'b10;
    endfunction

endpackage

// File: rtl/ihf_pkt_ram.sv
// Byte-wide packet store with a WB-byte write port and an RB-byte read port.
// Multi-byte accesses wrap modulo DEPTH (power of two).
module ihf_pkt_ram #(
    parameter int DEPTH = 64,
    parameter int WB    = 1,
    parameter int RB    = 1,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [WB*8-1:0] wdata,
    input  logic [AW-1:0]   raddr,
    output logic [RB*8-1:0] rdata
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int k = 0; k < WB; k++) begin
                mem[waddr + AW'(k)] <= wdata[k*8 +: 8];
            end
        end
    end

    for (genvar g = 0; g < RB; g++) begin : g_rd
        assign rdata[g*8 +: 8] = mem[raddr + AW'(g)];
    end

endmodule

// File: rtl/ihf_tx_model.sv
// Stand-in for the transmit datapath: busy for TX_CYCLES clocks per request.
module ihf_tx_model #(
    parameter int TX_CYCLES = 8,
    localparam int CW       = $clog2(TX_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic start,
    output logic busy,
    output logic done
);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } txm_t;

    txm_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (clear) begin
            m_d = '0;
        end else if (m_q.busy) begin
            if (m_q.cnt == '0) m_d.busy = 1'b0;
            else               m_d.cnt  = m_q.cnt - 1'b1;
        end else if (start) begin
            m_d.busy = 1'b1;
            m_d.cnt  = CW'(TX_CYCLES - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign busy = m_q.busy;
    assign done = m_q.busy && (m_q.cnt == '0) && !clear;

endmodule

// File: rtl/idx_host_if.sv
module idx_host_if
    import ihf_pkg::*;
#(
    parameter int         DATA_W    = 8,
    parameter int         RX_DEPTH  = 64,
    parameter int         TX_DEPTH  = 64,
    parameter int         RST_CLKS  = 16,
    parameter int         TX_CYCLES = 8,
    parameter logic [7:0] REV_CODE  = 8'h1A,
    localparam int        NB        = DATA_W / 8,
    localparam int        RAW       = $clog2(RX_DEPTH),
    localparam int        TAW       = $clog2(TX_DEPTH),
    localparam int        RCW       = $clog2(RST_CLKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cmd,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_ld_we,
    input  logic [RAW-1:0]    rx_ld_addr,
    input  logic [7:0]        rx_ld_data,
    input  logic              rx_arrive,
    input  logic [TAW-1:0]    tx_peek_addr,
    output logic [7:0]        tx_peek_data
);

    typedef struct packed {
        logic [7:0]     idx;
        logic [1:0]     lbk;
        logic           rst_act;
        logic [RCW-1:0] rst_cnt;
        logic           txend;
        logic [15:0]    txlen;
        logic [RAW-1:0] rx_ptr;
        logic [TAW-1:0] tx_ptr;
        logic [5:0]     isr;
    } st_t;

    st_t st_d, st_q;

    logic              tx_start, tx_busy, tx_done, txram_we;
    logic [DATA_W-1:0] rx_word;
    logic [7:0]        wb, reg8;
    logic [15:0]       rxp16, txp16;
    logic              dwr, drd;

    assign wb    = bus_wdata[7:0];
    assign dwr   = bus_wr && !bus_cmd;
    assign drd   = bus_rd && !bus_cmd;
    assign rxp16 = 16'(st_q.rx_ptr);
    assign txp16 = 16'(st_q.tx_ptr);

    // next-state computation
    always_comb begin
        st_d     = st_q;
        tx_start = 1'b0;
        txram_we = 1'b0;
        if (bus_wr && bus_cmd) st_d.idx = wb;
        if (st_q.rst_act) begin
            st_d.lbk    = '0;
            st_d.txend  = 1'b0;
            st_d.txlen  = '0;
            st_d.rx_ptr = '0;
            st_d.tx_ptr = '0;
            st_d.isr    = '0;
            if (st_q.rst_cnt == '0) st_d.rst_act = 1'b0;
            else                    st_d.rst_cnt = st_q.rst_cnt - 1'b1;
        end else begin
            if (drd && st_q.idx == IX_RXINC) st_d.rx_ptr = st_q.rx_ptr + RAW'(NB);
            if (dwr) begin
                case (st_q.idx)
                    IX_NCTL: begin
                        st_d.lbk = wb[2:1];
                        if (wb[0]) begin
                            st_d.rst_act = 1'b1;
                            st_d.rst_cnt = RCW'(RST_CLKS - 1);
                        end
                    end
                    IX_NSTAT: if (wb[2]) st_d.txend = 1'b0;
                    IX_TCTL:  tx_start = wb[0] && !tx_busy;
                    IX_RXP_L: st_d.rx_ptr = RAW'({rxp16[15:8], wb});
                    IX_RXP_H: st_d.rx_ptr = RAW'({wb, rxp16[7:0]});
                    IX_TXP_L: st_d.tx_ptr = TAW'({txp16[15:8], wb});
                    IX_TXP_H: st_d.tx_ptr = TAW'({wb, txp16[7:0]});
                    IX_TXWR: begin
                        txram_we    = 1'b1;
                        st_d.tx_ptr = st_q.tx_ptr + TAW'(NB);
                    end
                    IX_LEN_L: st_d.txlen[7:0]  = wb;
                    IX_LEN_H: st_d.txlen[15:8] = wb;
                    IX_IRQ:   st_d.isr = st_q.isr & ~wb[5:0];
                    default: ;
                endcase
            end
            // set events take priority over a clear in the same cycle
            if (tx_done) begin
                st_d.txend  = 1'b1;
                st_d.isr[1] = 1'b1;
            end
            if (rx_arrive) st_d.isr[0] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // register read multiplexer
    always_comb begin
        case (st_q.idx)
            IX_NCTL:  reg8 = {5'b0, st_q.lbk, st_q.rst_act};
            IX_NSTAT: reg8 = {5'b0, st_q.txend, 2'b0};
            IX_TCTL:  reg8 = {7'b0, tx_busy};
            IX_ID0:   reg8 = DEV_ID[7:0];
            IX_ID1:   reg8 = DEV_ID[15:8];
            IX_ID2:   reg8 = DEV_ID[23:16];
            IX_ID3:   reg8 = DEV_ID[31:24];
            IX_REV:   reg8 = REV_CODE;
            IX_RXP_L: reg8 = rxp16[7:0];
            IX_RXP_H: reg8 = rxp16[15:8];
            IX_TXP_L: reg8 = txp16[7:0];
            IX_TXP_H: reg8 = txp16[15:8];
            IX_LEN_L: reg8 = st_q.txlen[7:0];
            IX_LEN_H: reg8 = st_q.txlen[15:8];
            IX_IRQ:   reg8 = {width_code(DATA_W), st_q.isr};
            default:  reg8 = 8'h00;
        endcase
    end

    always_comb begin
        if (bus_cmd)
            bus_rdata = DATA_W'(st_q.idx);
        else if (st_q.idx == IX_RXPK || st_q.idx == IX_RXINC)
            bus_rdata = rx_word;
        else
            bus_rdata = DATA_W'(reg8);
    end

    ihf_pkt_ram #(.DEPTH(RX_DEPTH), .WB(1), .RB(NB)) u_rx_ram (
        .clk   (clk),
        .we    (rx_ld_we),
        .waddr (rx_ld_addr),
        .wdata (rx_ld_data),
        .raddr (st_q.rx_ptr),
        .rdata (rx_word)
    );

    ihf_pkt_ram #(.DEPTH(TX_DEPTH), .WB(NB), .RB(1)) u_tx_ram (
        .clk   (clk),
        .we    (txram_we),
        .waddr (st_q.tx_ptr),
        .wdata (bus_wdata),
        .raddr (tx_peek_addr),
        .rdata (tx_peek_data)
    );

    ihf_tx_model #(.TX_CYCLES(TX_CYCLES)) u_txm (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (st_q.rst_act),
        .start (tx_start),
        .busy  (tx_busy),
        .done  (tx_done)
    );

endmodule

// File: rtl/ihf_chk.sv
module ihf_chk #(
    parameter int  DATA_W   = 8,
    parameter int  RX_DEPTH = 64,
    parameter int  RST_CLKS = 16,
    localparam int NB       = DATA_W / 8,
    localparam int RAW      = $clog2(RX_DEPTH)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_cmd,
    input logic           bus_wr,
    input logic           bus_rd,
    input logic           wdata0,
    input logic [7:0]     idx,
    input logic [RAW-1:0] rx_ptr,
    input logic           tx_busy,
    input logic           rst_act,
    input logic           txend,
    input logic [5:0]     isr,
    input logic [15:0]    txlen,
    input logic           rx_arrive
);

    logic [15:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       run_q <= '0;
        else if (rst_act) run_q <= run_q + 16'd1;
        else              run_q <= '0;
    end

    p_rst_len_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_act |-> run_q < 16'(RST_CLKS));

    p_defaults_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_act |=> (txlen == 16'h0 && rx_ptr == '0));

    p_peek_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_act && bus_rd && !bus_wr && !bus_cmd && idx == 8'hF0)
        |=> rx_ptr == $past(rx_ptr));

    p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_act && bus_rd && !bus_wr && !bus_cmd && idx == 8'hF2)
        |=> rx_ptr == $past(rx_ptr) + RAW'(NB));

    p_txdone_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(tx_busy) && !$past(rst_act)) |-> (txend && isr[1]));

    p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_act && bus_wr && !bus_cmd && idx == 8'hFE && wdata0 && !rx_arrive)
        |=> !isr[0]);

endmodule

bind idx_host_if ihf_chk #(
    .DATA_W   (DATA_W),
    .RX_DEPTH (RX_DEPTH),
    .RST_CLKS (RST_CLKS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_cmd   (bus_cmd),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .wdata0    (bus_wdata[0]),
    .idx       (st_q.idx),
    .rx_ptr    (st_q.rx_ptr),
    .tx_busy   (tx_busy),
    .rst_act   (st_q.rst_act),
    .txend     (st_q.txend),
    .isr       (st_q.isr),
    .txlen     (st_q.txlen),
    .rx_arrive (rx_arrive)
);

// File: tb/sim_idx_host_if.sv
`timescale 1ns/1ps
module sim_idx_host_if;

    localparam int DW  = 32;
    localparam int RXD = 64;
    localparam int TXD = 64;
    localparam int RAW = $clog2(RXD);
    localparam int TAW = $clog2(TXD);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_cmd = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [DW-1:0]  bus_wdata = '0;
    logic [DW-1:0]  bus_rdata;
    logic           rx_ld_we = 1'b0;
    logic [RAW-1:0] rx_ld_addr = '0;
    logic [7:0]     rx_ld_data = '0;
    logic           rx_arrive = 1'b0;
    logic [TAW-1:0] tx_peek_addr = '0;
    logic [7:0]     tx_peek_data;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    idx_host_if #(.DATA_W(DW), .RX_DEPTH(RXD), .TX_DEPTH(TXD),
                  .RST_CLKS(16), .TX_CYCLES(8), .REV_CODE(8'h1A)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_cmd(bus_cmd), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_ld_we(rx_ld_we), .rx_ld_addr(rx_ld_addr), .rx_ld_data(rx_ld_data),
        .rx_arrive(rx_arrive), .tx_peek_addr(tx_peek_addr), .tx_peek_data(tx_peek_data)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic [7:0]  ix;
        logic [31:0] exp;
    } vec_t;

    // reset-state register reads: R1 R2 R4 R7 R8 R10 R11
    localparam vec_t VECS [11] = '{
        '{8'd2,  8'h28, 32'h46}, '{8'd2,  8'h29, 32'h0A},
        '{8'd2,  8'h2A, 32'h00}, '{8'd2,  8'h2B, 32'h90},
        '{8'd2,  8'h2C, 32'h1A}, '{8'd10, 8'hFE, 32'h40},
        '{8'd11, 8'h00, 32'h00}, '{8'd8,  8'h02, 32'h00},
        '{8'd7,  8'hFC, 32'h00}, '{8'd4,  8'hF4, 32'h00},
        '{8'd1,  8'h77, 32'h00}
    };

    function automatic logic [7:0] rx_byte(int a);
        case (a)
            0: return 8'h01;
            1: return 8'h00;
            2: return 8'h40;
            3: return 8'h00;
            default: return 8'(a) ^ 8'h5A;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // all host tasks start and end just after a falling edge
    task automatic put_idx(logic [7:0] v);
        bus_cmd = 1'b1; bus_wr = 1'b1; bus_wdata = DW'(v);
        @(negedge clk);
        bus_wr = 1'b0; bus_cmd = 1'b0;
    endtask

    task automatic put_data(logic [DW-1:0] v);
        bus_cmd = 1'b0; bus_wr = 1'b1; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic get_data(output logic [DW-1:0] r);
        bus_cmd = 1'b0; bus_rd = 1'b1;
        #1 r = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_reg(logic [7:0] ix, output logic [DW-1:0] r);
        put_idx(ix);
        get_data(r);
    endtask

    task automatic wr_reg(logic [7:0] ix, logic [DW-1:0] v);
        put_idx(ix);
        put_data(v);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [DW-1:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // table of reset-state reads
        foreach (VECS[i]) begin
            rd_reg(VECS[i].ix, r);
            chk($sformatf("R%0d idx %h", VECS[i].req, VECS[i].ix), r, VECS[i].exp);
        end

        // R1: index port readback
        put_idx(8'hFD);
        bus_cmd = 1'b1; #1 chk("R1 index readback", bus_rdata, 32'hFD); bus_cmd = 1'b0;
        @(negedge clk);

        // R7: length bytes, R1 targeting
        wr_reg(8'hFC, 32'h34);
        wr_reg(8'hFD, 32'h12);
        rd_reg(8'hFC, r); chk("R7 length low", r, 32'h34);
        rd_reg(8'hFD, r); chk("R7 length high", r, 32'h12);

        // load receive memory
        for (int a = 0; a < RXD; a++) begin
            rx_ld_we = 1'b1; rx_ld_addr = RAW'(a); rx_ld_data = rx_byte(a);
            @(negedge clk);
        end
        rx_ld_we = 1'b0;

        // R3: peek without advance
        rd_reg(8'hF0, r); chk("R3 peek header", r, 32'h00400001);
        get_data(r);      chk("R3 peek repeat", r, 32'h00400001);
        rd_reg(8'hF4, r); chk("R3 pointer unmoved", r, 32'h0);

        // R4: auto-increment reads
        rd_reg(8'hF2, r); chk("R4 first word", r, 32'h00400001);
        get_data(r);
        chk("R4 second word", r, {rx_byte(7), rx_byte(6), rx_byte(5), rx_byte(4)});
        rd_reg(8'hF4, r); chk("R4 pointer advanced", r, 32'h8);

        // R6: read wrap
        wr_reg(8'hF4, 32'h3E);
        rd_reg(8'hF2, r);
        chk("R6 rx wrap word", r, {rx_byte(1), rx_byte(0), rx_byte(63), rx_byte(62)});
        rd_reg(8'hF4, r); chk("R6 rx pointer wrap", r, 32'h2);

        // R5: transmit memory writes
        wr_reg(8'hFA, 32'h0);
        put_idx(8'hF8);
        put_data(32'h11223344);
        put_data(32'h55667788);
        begin
            logic [7:0] exp_tx [8] = '{8'h44, 8'h33, 8'h22, 8'h11, 8'h88, 8'h77, 8'h66, 8'h55};
            for (int a = 0; a < 8; a++) begin
                tx_peek_addr = TAW'(a);
                #1 chk($sformatf("R5 tx byte %0d", a), 32'(tx_peek_data), 32'(exp_tx[a]));
            end
        end
        rd_reg(8'hFA, r); chk("R5 tx pointer", r, 32'h8);

        // R6: write wrap
        wr_reg(8'hFA, 32'h3E);
        wr_reg(8'hF8, 32'hAABBCCDD);
        tx_peek_addr = 6'd62; #1 chk("R6 tx 62", 32'(tx_peek_data), 32'hDD);
        tx_peek_addr = 6'd63; #1 chk("R6 tx 63", 32'(tx_peek_data), 32'hCC);
        tx_peek_addr = 6'd0;  #1 chk("R6 tx 0",  32'(tx_peek_data), 32'hBB);
        tx_peek_addr = 6'd1;  #1 chk("R6 tx 1",  32'(tx_peek_data), 32'hAA);
        rd_reg(8'hFA, r); chk("R6 tx pointer wrap", r, 32'h2);

        // R8: send request timing
        wr_reg(8'h02, 32'h1);
        #1 chk("R8 busy at start", bus_rdata, 32'h1);
        repeat (7) @(negedge clk);
        #1 chk("R8 busy last cycle", bus_rdata, 32'h1);
        @(negedge clk);
        #1 chk("R8 busy cleared", bus_rdata, 32'h0);
        rd_reg(8'h01, r); chk("R8 tx end flag", r, 32'h04);
        rd_reg(8'hFE, r); chk("R8 irq sent bit", r, 32'h42);
        wr_reg(8'h01, 32'h04);
        rd_reg(8'h01, r); chk("R8 tx end cleared", r, 32'h0);

        // R9: event register
        rx_arrive = 1'b1; @(negedge clk); rx_arrive = 1'b0;
        rd_reg(8'hFE, r); chk("R9 rx event set", r, 32'h43);
        put_data(32'h02);
        get_data(r); chk("R9 clear bit1", r, 32'h41);
        put_data(32'h00);
        get_data(r); chk("R9 zero write no effect", r, 32'h41);
        rx_arrive = 1'b1;
        put_data(32'h01);
        rx_arrive = 1'b0;
        get_data(r); chk("R9 set wins over clear", r, 32'h41);
        put_data(32'hC1);
        get_data(r); chk("R10 width code kept", r, 32'h40);

        // R11: loopback field, then soft reset
        wr_reg(8'h00, 32'h06);
        rd_reg(8'h00, r); chk("R11 loopback readback", r, 32'h06);
        put_data(32'h01);
        #1 chk("R11 reset bit set", bus_rdata, 32'h01);
        put_idx(8'hFC);
        put_data(32'h99);
        #1 chk("R11 length defaulted", bus_rdata, 32'h0);
        put_idx(8'h00);
        repeat (12) @(negedge clk);
        #1 chk("R11 reset last cycle", bus_rdata, 32'h01);
        @(negedge clk);
        #1 chk("R11 reset released", bus_rdata, 32'h0);
        rd_reg(8'hFC, r); chk("R11 write ignored in reset", r, 32'h0);
        rd_reg(8'hF4, r); chk("R11 rx pointer default", r, 32'h0);
        rd_reg(8'hFE, r); chk("R11 irq default", r, 32'h40);
        rd_reg(8'h28, r); chk("R11 id kept", r, 32'h46);

        finish_run();
    end

endmodule